// File: doc/BRIEF.md
# Chained-Descriptor Transmit DMA with Hold Control

This block is the transmit half of a descriptor-driven DMA channel. Software builds a chain of descriptors in shared memory, gives the block the address of the first one and pulses a start strobe. For each descriptor the block reads the control word, the data pointer and the link to the next descriptor. It then fetches the data section byte by byte from any byte alignment and pushes the bytes into the transmit FIFO. When the last byte goes out it marks the descriptor done in memory.

The hold flag in a descriptor decides what happens after it completes. With hold clear, the block follows the link straight away. With hold set, it parks on that descriptor. If that descriptor also lacked frame end, the serial channel is told to abort the open frame and an error interrupt fires. While parked, a host poll strobe makes the block reread the control word. Once software has cleared hold there, traversal resumes at the stored link.

Top module: `tx_dma_chain`

## Requirements
- R1: After a start strobe (accepted while idle or parked), the block reads the descriptor at `start_addr`. It pushes exactly the section's byte count into the FIFO, taking bytes from ascending byte addresses starting at the data pointer, whatever the pointer's alignment. Memory words are little-endian: byte address A sits in lane A mod 4.
- R2: A descriptor is three consecutive 32-bit words: control at offset 0, data pointer at offset 4, next-descriptor address at offset 8. A memory request holds its address and direction stable until `mem_ack`.
- R3: `fifo_fe` is high together with the push of a section's last byte only when control bit 16 (frame end) is set. It is never high on any other push.
- R4: After the section's data, the block writes the control word back with bit 31 (done) set and every other bit unchanged.
- R5: When control bit 17 (hold) is clear, the block continues with the descriptor named by the next-descriptor word.
- R6: When hold is set, the block stops after the write-back with `held` high. It then issues no pushes and no memory requests until a poll or start.
- R7: A completed descriptor with hold set and frame end clear produces one-cycle pulses on `tx_abort` and `irq_err`, once each.
- R8: A completed descriptor with frame end set pulses `irq_done` once if `done_irq_en` is high, and not at all if it is low.
- R9: A completed descriptor with control bit 18 (host interrupt) set pulses `irq_host` once, regardless of `done_irq_en`.
- R10: While `fifo_full` is high, no push occurs and the pending byte is held. No byte is lost or repeated.
- R11: A `poll` strobe while parked rereads the control word. If hold is still set, the block stays parked without pushing. If hold is clear, it resumes at the stored next-descriptor address.
- R12: A byte count (control bits 15:0) of zero completes the descriptor with no push.
- R13: During and straight after reset, `mem_req`, `fifo_push`, `held` and all event outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin traversal at `start_addr` |
| start_addr | input | AW | Byte address of first descriptor |
| poll | input | 1 | Host strobe to recheck hold while parked |
| done_irq_en | input | 1 | Enables the frame-complete interrupt |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address of the access (word aligned) |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access complete |
| fifo_full | input | 1 | FIFO cannot accept a byte |
| fifo_push | output | 1 | Byte push strobe |
| fifo_data | output | 8 | Pushed byte |
| fifo_fe | output | 1 | Frame end, with the last byte of a frame |
| tx_abort | output | 1 | Abort the open frame (underrun) |
| irq_done | output | 1 | Frame-complete event |
| irq_host | output | 1 | Host-requested event |
| irq_err | output | 1 | Hold-without-frame-end error event |
| held | output | 1 | Parked on a held descriptor |

## Verification
The single-descriptor sweep runs every data-pointer alignment against byte counts 0 to 9. This separates word-lane selection faults, refetches at word boundaries, off-by-one counting and the zero-length path. Odd counts run with the FIFO full two cycles out of three, so stall handling is checked against the same expected byte stream. A three-descriptor chain with mixed flags checks link following, frame-end placement across descriptors and the host interrupt. Separate runs cover hold without frame end, polls with hold set and then cleared, and the masked completion interrupt.

// File: rtl/tdma_pkg.sv
// Shared definitions for the chained transmit DMA.
// Assumes 32-bit descriptor words; control word layout is fixed here.
package tdma_pkg;
    localparam int CNT_W    = 16;
    localparam int FE_BIT   = 16;
    localparam int HOLD_BIT = 17;
    localparam int HINT_BIT = 18;
    localparam int DONE_BIT = 31;

    typedef enum logic [3:0] {
        S_IDLE, S_RCTL, S_RPTR, S_RNXT, S_RDAT,
        S_PUSH, S_WDONE, S_HELD, S_POLL
    } seq_t;

    typedef struct packed {
        logic             fe;
        logic             hold;
        logic             hint;
        logic [CNT_W-1:0] cnt;
    } ctl_t;
endpackage

// File: rtl/tdma_byte_src.sv
// Byte source: tracks the byte pointer and remaining count of a data
// section, holds the last fetched memory word and selects the current lane.
// Assumes DW is a power-of-two multiple of 8 and load/advance never coincide.
module tdma_byte_src #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_ptr,
    input  logic [CW-1:0] load_cnt,
    input  logic          word_load,
    input  logic [DW-1:0] word_in,
    input  logic          advance,
    output logic [AW-1:0] word_addr,
    output logic [7:0]    byte_out,
    output logic          cnt_zero,
    output logic          cnt_last,
    output logic          lane_last
);
    localparam int BYTES = DW / 8;
    localparam int LW    = $clog2(BYTES);

    logic [AW-1:0] ptr;
    logic [CW-1:0] cnt;
    logic [DW-1:0] word;
    logic [LW-1:0] lane;

    assign lane = ptr[LW-1:0];

    // Pointer and count: load at section start, step once per pushed byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
            cnt <= '0;
        end else if (load) begin
            ptr <= load_ptr;
            cnt <= load_cnt;
        end else if (advance) begin
            ptr <= ptr + 1'b1;
            cnt <= cnt - 1'b1;
        end
    end

    // Word buffer: keeps the memory word that holds the current lane.
    always_ff @(posedge clk) begin
        if (!rst_n)         word <= '0;
        else if (word_load) word <= word_in;
    end

    assign word_addr = {ptr[AW-1:LW], {LW{1'b0}}};
    assign byte_out  = word[{lane, 3'b000} +: 8];
    assign cnt_zero  = (cnt == '0);
    assign cnt_last  = (cnt == CW'(1));
    assign lane_last = &lane;

    p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> cnt == $past(cnt) - 1'b1);
    p_no_empty_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> !cnt_zero);
endmodule

// File: rtl/tdma_events.sv
// Event generator: turns a descriptor completion and its flags into
// registered one-cycle interrupt and abort pulses.
// Assumes 'fire' is high for one cycle per completed descriptor.
module tdma_events (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic fe,
    input  logic hold,
    input  logic hint,
    input  logic done_en,
    output logic irq_done,
    output logic irq_host,
    output logic irq_err,
    output logic tx_abort
);
    // Pulse register: decode completion flags into the four event outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_done <= 1'b0;
            irq_host <= 1'b0;
            irq_err  <= 1'b0;
            tx_abort <= 1'b0;
        end else begin
            irq_done <= fire && fe && done_en;
            irq_host <= fire && hint;
            irq_err  <= fire && hold && !fe;
            tx_abort <= fire && hold && !fe;
        end
    end

    p_done_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |-> $past(done_en));
    p_err_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err |=> !irq_err);
endmodule

// File: rtl/tx_dma_chain.sv
// Chained-descriptor transmit DMA. Walks descriptors of three words
// (control, data pointer, next pointer), streams each data section into a
// byte FIFO, writes a done mark back and then follows or parks on hold.
// Assumes a memory that answers each request with one mem_ack cycle and
// keeps rdata valid in that cycle; DW >= 32 and AW <= DW.
module tx_dma_chain #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic          poll,
    input  logic          done_irq_en,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ack,
    input  logic          fifo_full,
    output logic          fifo_push,
    output logic [7:0]    fifo_data,
    output logic          fifo_fe,
    output logic          tx_abort,
    output logic          irq_done,
    output logic          irq_host,
    output logic          irq_err,
    output logic          held
);
    import tdma_pkg::*;

    localparam int            BPW     = DW / 8;
    localparam logic [AW-1:0] OFS_PTR = AW'(BPW);
    localparam logic [AW-1:0] OFS_NXT = AW'(2 * BPW);

    seq_t          st, st_nx;
    logic [AW-1:0] cur, nxt_ptr;
    ctl_t          ctl;
    logic [DW-1:0] ctl_raw;
    logic          acc, fire;
    logic [AW-1:0] word_addr;
    logic          cnt_zero, cnt_last, lane_last;

    assign acc  = mem_req && mem_ack;
    assign fire = (st == S_WDONE) && acc;

    // Next-state logic of the descriptor sequencer.
    always_comb begin
        st_nx = st;
        case (st)
            S_IDLE:  if (start) st_nx = S_RCTL;
            S_RCTL:  if (acc) st_nx = S_RPTR;
            S_RPTR:  if (acc) st_nx = S_RNXT;
            S_RNXT:  if (acc) st_nx = cnt_zero ? S_WDONE : S_RDAT;
            S_RDAT:  if (acc) st_nx = S_PUSH;
            S_PUSH: begin
                if (fifo_push) begin
                    if (cnt_last)       st_nx = S_WDONE;
                    else if (lane_last) st_nx = S_RDAT;
                end
            end
            S_WDONE: if (acc) st_nx = ctl.hold ? S_HELD : S_RCTL;
            S_HELD: begin
                if (start)     st_nx = S_RCTL;
                else if (poll) st_nx = S_POLL;
            end
            S_POLL:  if (acc) st_nx = mem_rdata[HOLD_BIT] ? S_HELD : S_RCTL;
            default: st_nx = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // Current-descriptor address: set by start, advanced along the link.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= '0;
        end else if ((st == S_IDLE || st == S_HELD) && start) begin
            cur <= start_addr;
        end else if (fire && !ctl.hold) begin
            cur <= nxt_ptr;
        end else if (st == S_POLL && acc && !mem_rdata[HOLD_BIT]) begin
            cur <= nxt_ptr;
        end
    end

    // Descriptor fields captured as the control and link words arrive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl     <= '0;
            ctl_raw <= '0;
            nxt_ptr <= '0;
        end else begin
            if (st == S_RCTL && acc) begin
                ctl_raw  <= mem_rdata;
                ctl.fe   <= mem_rdata[FE_BIT];
                ctl.hold <= mem_rdata[HOLD_BIT];
                ctl.hint <= mem_rdata[HINT_BIT];
                ctl.cnt  <= mem_rdata[CNT_W-1:0];
            end
            if (st == S_RNXT && acc) nxt_ptr <= mem_rdata[AW-1:0];
        end
    end

    // Memory port: request, direction, address and write-back data.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur;
        mem_wdata = ctl_raw;
        mem_wdata[DONE_BIT] = 1'b1;
        case (st)
            S_RCTL, S_POLL: mem_req = 1'b1;
            S_RPTR: begin mem_req = 1'b1; mem_addr = cur + OFS_PTR; end
            S_RNXT: begin mem_req = 1'b1; mem_addr = cur + OFS_NXT; end
            S_RDAT: begin mem_req = 1'b1; mem_addr = word_addr; end
            S_WDONE: begin mem_req = 1'b1; mem_we = 1'b1; end
            default: ;
        endcase
    end

    assign fifo_push = (st == S_PUSH) && !fifo_full;
    assign fifo_fe   = fifo_push && cnt_last && ctl.fe;
    assign held      = (st == S_HELD);

    tdma_byte_src #(.AW(AW), .DW(DW), .CW(CNT_W)) u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (st == S_RPTR && acc),
        .load_ptr  (mem_rdata[AW-1:0]),
        .load_cnt  (ctl.cnt),
        .word_load (st == S_RDAT && acc),
        .word_in   (mem_rdata),
        .advance   (fifo_push),
        .word_addr (word_addr),
        .byte_out  (fifo_data),
        .cnt_zero  (cnt_zero),
        .cnt_last  (cnt_last),
        .lane_last (lane_last)
    );

    tdma_events u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .fe       (ctl.fe),
        .hold     (ctl.hold),
        .hint     (ctl.hint),
        .done_en  (done_irq_en),
        .irq_done (irq_done),
        .irq_host (irq_host),
        .irq_err  (irq_err),
        .tx_abort (tx_abort)
    );

    p_req_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
    p_stall_keeps_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_PUSH) && fifo_full |=> $stable(fifo_data));
    p_fe_then_writeback_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_fe |=> mem_req && mem_we);
    p_held_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        held |-> !fifo_push && !mem_req);
    p_err_parks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err |-> held && tx_abort);
endmodule

// File: tb/sim_tx_dma_chain.sv
module sim_tx_dma_chain;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, poll = 1'b0, done_irq_en = 1'b1;
    logic [31:0] start_addr = '0;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic        fifo_full = 1'b0, fifo_push, fifo_fe;
    logic [7:0]  fifo_data;
    logic        tx_abort, irq_done, irq_host, irq_err, held;

    always #5 clk = ~clk;

    tx_dma_chain u0 (.*);

    logic [31:0] mem [0:255];
    logic [31:0] wb  [0:255];
    int          wb_gen [0:255];
    int          gen = 0;
    bit          full_pat = 0;
    int          n_chk = 0, n_fail = 0;
    int          pushes = 0, fe_cnt = 0, fe_pos = -1;
    int          c_done = 0, c_host = 0, c_err = 0, c_abort = 0;
    logic [7:0]  got [0:1023];

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 7 + 3) & 255);
    endfunction
    function automatic logic [31:0] ctlw(input int n, input bit fe, input bit hold, input bit hint);
        return {13'd0, hint, hold, fe, 16'(n)};
    endfunction
    function automatic logic [31:0] rdmem(input int a);
        int i = (a >> 2) & 255;
        return (wb_gen[i] == gen) ? wb[i] : mem[i];
    endfunction

    // memory model and FIFO back-pressure, driven 2 ns after each edge
    initial begin
        int cyc = 0;
        for (int i = 0; i < 256; i++) wb_gen[i] = -1;
        forever begin
            @(posedge clk); #2;
            cyc++;
            fifo_full = full_pat && (cyc % 3 != 0);
            if (mem_req && !mem_ack) begin
                mem_ack = 1'b1;
                if (mem_we) begin
                    wb[mem_addr[9:2]] = mem_wdata;
                    wb_gen[mem_addr[9:2]] = gen;
                end
                mem_rdata = rdmem(int'(mem_addr));
            end else begin
                mem_ack = 1'b0;
            end
        end
    end

    // output monitor at the falling edge
    initial forever begin
        @(negedge clk);
        if (rst_n) begin
            if (fifo_push) begin
                got[pushes & 1023] = fifo_data;
                if (fifo_fe) begin fe_cnt++; fe_pos = pushes; end
                pushes++;
            end
            if (irq_done) c_done++;
            if (irq_host) c_host++;
            if (irq_err)  c_err++;
            if (tx_abort) c_abort++;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail + 1);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] v);
        mem[(a >> 2) & 255] = v;
        gen++;
    endtask

    task automatic kick(input int a);
        @(posedge clk); #2; start_addr = 32'(a); start = 1'b1;
        @(posedge clk); #2; start = 1'b0;
    endtask

    task automatic pulse_poll();
        @(posedge clk); #2; poll = 1'b1;
        @(posedge clk); #2; poll = 1'b0;
    endtask

    task automatic wait_held(input string req);
        bit seen = 0;
        repeat (4) @(posedge clk);
        for (int k = 0; k < 3000 && !seen; k++) begin
            @(negedge clk);
            seen = held;
        end
        chk(seen, req, int'(seen), 1);
    endtask

    task automatic check_bytes(input int base, input int addr, input int n, input string req);
        int bad = -1;
        for (int j = 0; j < n; j++)
            if (got[(base + j) & 1023] !== pat(addr + j) && bad < 0) bad = j;
        chk(bad < 0, req, bad < 0 ? 0 : int'(got[(base + bad) & 1023]),
            bad < 0 ? 0 : int'(pat(addr + bad)));
    endtask

    initial begin
        int b_p, b_fe, b_d, b_h, b_e, b_a;
        for (int i = 0; i < 256; i++)
            for (int k = 0; k < 4; k++) mem[i][8*k +: 8] = pat(4 * i + k);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R13: reset state
        chk(!mem_req && !fifo_push && !held, "R13 reset idle", {mem_req, fifo_push, held}, 0);
        chk(!irq_done && !irq_host && !irq_err && !tx_abort, "R13 reset events",
            {irq_done, irq_host, irq_err, tx_abort}, 0);
        @(posedge clk); #2; rst_n = 1'b1;

        // sweep: every alignment against counts 0..9
        for (int off = 0; off < 4; off++) begin
            for (int n = 0; n < 10; n++) begin
                full_pat = (n % 2 == 1);
                wr(32'h100, ctlw(n, 1, 1, 0));
                wr(32'h104, 32'h200 + off);
                wr(32'h108, 32'h300);
                b_p = pushes; b_fe = fe_cnt; b_d = c_done; b_e = c_err;
                kick(32'h100);
                wait_held("R6 parks on hold");
                chk(pushes - b_p == n, n == 0 ? "R12 zero count" : "R1 byte count", pushes - b_p, n);
                check_bytes(b_p, 32'h200 + off, n, full_pat ? "R10 bytes under stall" : "R1 byte order");
                if (n > 0)
                    chk(fe_cnt - b_fe == 1 && fe_pos == b_p + n - 1, "R3 fe on last byte", fe_pos - b_p, n - 1);
                else
                    chk(fe_cnt == b_fe, "R3 no fe without bytes", fe_cnt - b_fe, 0);
                chk(rdmem(32'h100) == (ctlw(n, 1, 1, 0) | 32'h8000_0000), "R4 done write-back",
                    int'(rdmem(32'h100)), int'(ctlw(n, 1, 1, 0) | 32'h8000_0000));
                chk(c_done - b_d == 1 && c_err == b_e, "R8 done irq with fe", c_done - b_d, 1);
            end
        end

        // chain of three: link following, fe across descriptors, host irq, stalls
        full_pat = 1;
        wr(32'h100, ctlw(5, 0, 0, 1)); wr(32'h104, 32'h201); wr(32'h108, 32'h140);
        wr(32'h140, ctlw(3, 1, 0, 0)); wr(32'h144, 32'h20A); wr(32'h148, 32'h180);
        wr(32'h180, ctlw(6, 1, 1, 0)); wr(32'h184, 32'h213); wr(32'h188, 32'h100);
        b_p = pushes; b_fe = fe_cnt; b_d = c_done; b_h = c_host;
        kick(32'h100);
        wait_held("R5 chain ends on hold");
        chk(pushes - b_p == 14, "R5 chain byte total", pushes - b_p, 14);
        check_bytes(b_p, 32'h201, 5, "R5 first section");
        check_bytes(b_p + 5, 32'h20A, 3, "R5 second section");
        check_bytes(b_p + 8, 32'h213, 6, "R5 third section");
        chk(fe_cnt - b_fe == 2 && fe_pos == b_p + 13, "R3 fe per frame", fe_cnt - b_fe, 2);
        chk(c_host - b_h == 1, "R9 host irq", c_host - b_h, 1);
        chk(c_done - b_d == 2, "R8 two frames done", c_done - b_d, 2);
        chk(rdmem(32'h100)[31] && rdmem(32'h140)[31] && rdmem(32'h180)[31], "R4 all marked", 0, 1);
        full_pat = 0;

        // hold without frame end
        wr(32'h100, ctlw(2, 0, 1, 0)); wr(32'h104, 32'h230); wr(32'h108, 32'h300);
        wr(32'h300, ctlw(4, 1, 1, 0)); wr(32'h304, 32'h240); wr(32'h308, 32'h100);
        b_p = pushes; b_d = c_done; b_e = c_err; b_a = c_abort;
        kick(32'h100);
        wait_held("R7 parks after error");
        chk(c_err - b_e == 1 && c_abort - b_a == 1, "R7 abort and error", c_err - b_e, 1);
        chk(c_done == b_d, "R7 no done irq", c_done - b_d, 0);
        chk(fe_cnt == b_fe + 2 && pushes - b_p == 2, "R3 no fe when flag clear", pushes - b_p, 2);

        // poll while hold still set
        b_p = pushes;
        pulse_poll();
        repeat (10) @(posedge clk);
        @(negedge clk);
        chk(held && pushes == b_p, "R11 poll keeps hold", pushes - b_p, 0);
        repeat (10) @(posedge clk);
        @(negedge clk);
        chk(pushes == b_p && !mem_req, "R6 quiet while held", pushes - b_p, 0);

        // clear hold, poll resumes at the stored link
        wr(32'h100, ctlw(2, 0, 0, 0) | 32'h8000_0000);
        b_p = pushes;
        pulse_poll();
        wait_held("R11 resumes then parks");
        chk(pushes - b_p == 4, "R11 resumed section", pushes - b_p, 4);
        check_bytes(b_p, 32'h240, 4, "R11 resumed bytes");

        // masked completion interrupt, host irq unmasked
        done_irq_en = 1'b0;
        wr(32'h100, ctlw(1, 1, 1, 1)); wr(32'h104, 32'h250); wr(32'h108, 32'h300);
        b_d = c_done; b_h = c_host;
        kick(32'h100);
        wait_held("R6 parks masked run");
        chk(c_done == b_d, "R8 masked done irq", c_done - b_d, 0);
        chk(c_host - b_h == 1, "R9 host irq ignores mask", c_host - b_h, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule